// File: doc/BRIEF.md
# Synchronous RAM Sleep Controller

This block governs the low-power sleep state of a pipelined synchronous RAM. A raw, asynchronous, active-high sleep pin is brought into the clock domain through a chain of flops. A fixed latency then applies on the way into sleep, and another on the way out. From the start of entry until the end of a recovery window after exit, the block holds an access-inhibit line high. The RAM uses that line to drop any pending access, to keep its stored contents untouched and to hold its data pins in three-state.

The recovery window follows the exit latency. During that window the chip selects and both address strobes must stay inactive. The block raises a one-cycle protocol-error pulse when the surrounding logic breaks that rule, and the offending request is not accepted. A sleep request that arrives while the device is selected is also flagged. In that case entry is held back until a cycle with no select. A pin held low, which is the undriven default, leaves the device awake.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, sleep_active, access_inhibit and proto_err are all 0, and they stay 0 while sleep_pin is held low.
- R2: When sleep_pin rises before clock edge k with no select present, access_inhibit goes high after edge k+2 and sleep_active goes high after edge k+4. This uses the default of two synchronizer stages and a two-cycle entry latency.
- R3: If the synchronized sleep request drops while entry is still under way, the block returns to awake and both access_inhibit and sleep_active fall back to 0.
- R4: While sleep_active is 1, access_inhibit is 1. Selects and strobes presented during sleep are blocked and raise no proto_err.
- R5: When sleep_pin falls before edge k, sleep_active goes low after edge k+4, which is a two-cycle exit latency. access_inhibit stays high for a further RECOVER_CYCLES cycles (default 4) and goes low after edge k+4+RECOVER_CYCLES.
- R6: If the synchronized sleep request comes back during the exit latency, the block returns to sleep and does not start recovery.
- R7: During the recovery window, a 1 sampled on any of cs_active, strobe_proc or strobe_ctrl raises proto_err for one cycle after that edge. The window is neither extended nor cut short by this.
- R8: When the synchronized sleep request is present while awake and cs_active is 1 together with at least one strobe, proto_err pulses on the next cycle and entry does not begin on that edge. Entry begins on the first edge with no such select.
- R9: While awake and with no sleep request, selects and strobes of any pattern never raise proto_err or access_inhibit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_pin | input | 1 | Raw asynchronous sleep request, active high |
| cs_active | input | 1 | All chip selects currently active |
| strobe_proc | input | 1 | Processor-side address strobe, active high |
| strobe_ctrl | input | 1 | Controller-side address strobe, active high |
| sleep_active | output | 1 | Device is asleep, including the exit latency |
| access_inhibit | output | 1 | Accesses blocked and data pins forced to three-state |
| proto_err | output | 1 | One-cycle pulse on a select-rule violation |

## Verification
A wrong state or a miscounted latency shows up at once as a shifted edge on access_inhibit or sleep_active. The reference model compares both lines on every cycle, so a one-cycle slip fails on the first cycle it occurs. A guard that checks the wrong phase shows up as a proto_err pulse that is missing or extra, one cycle after the offending strobe. A missing synchronizer stage moves every transition one cycle earlier, and an aborted entry or exit that is handled wrongly leaves the device asleep or awake for cycles where the model says otherwise.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [2:0] {
    SLP_AWAKE   = 3'd0,
    SLP_ENTER   = 3'd1,
    SLP_ASLEEP  = 3'd2,
    SLP_EXIT    = 3'd3,
    SLP_RECOVER = 3'd4
  } slp_state_t;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_dcnt.sv
module sleep_dcnt #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             zero
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // after a load of value v, zero is reached exactly when v was zero or later
  p_dcnt_load_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> zero);
endmodule

// File: rtl/sleep_guard.sv
module sleep_guard
  import sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_t state,
  input  logic       sync_sleep,
  input  logic       cs_active,
  input  logic       strobe_proc,
  input  logic       strobe_ctrl,
  output logic       sel_now,
  output logic       proto_err
);
  logic any_sel;
  logic bad_recover;
  logic bad_entry;

  assign any_sel     = cs_active | strobe_proc | strobe_ctrl;
  assign sel_now     = cs_active & (strobe_proc | strobe_ctrl);
  assign bad_recover = (state == SLP_RECOVER) & any_sel;
  assign bad_entry   = (state == SLP_AWAKE) & sync_sleep & sel_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= bad_recover | bad_entry;
  end

  // an error pulse only follows a cycle spent awake or recovering
  p_err_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> ($past(state) == SLP_RECOVER || $past(state) == SLP_AWAKE));

  // an error raised from the awake phase needs a pending sleep request
  p_err_entry_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && $past(state) == SLP_AWAKE) |-> $past(sync_sleep));
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int ENTRY_CYCLES   = 2,
  parameter int EXIT_CYCLES    = 2,
  parameter int RECOVER_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_pin,
  input  logic cs_active,
  input  logic strobe_proc,
  input  logic strobe_ctrl,
  output logic sleep_active,
  output logic access_inhibit,
  output logic proto_err
);
  localparam int MAX_A = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int MAX_C = (MAX_A > RECOVER_CYCLES) ? MAX_A : RECOVER_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LD_ENTRY = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_EXIT  = CNT_W'(EXIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(RECOVER_CYCLES - 1);

  slp_state_t       state_q, state_d;
  logic             sync_sleep;
  logic             sel_now;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sleep_pin),
    .sync_out (sync_sleep)
  );

  sleep_dcnt #(.WIDTH(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  sleep_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .sync_sleep  (sync_sleep),
    .cs_active   (cs_active),
    .strobe_proc (strobe_proc),
    .strobe_ctrl (strobe_ctrl),
    .sel_now     (sel_now),
    .proto_err   (proto_err)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      SLP_AWAKE: begin
        if (sync_sleep && !sel_now) begin
          state_d  = SLP_ENTER;
          cnt_load = 1'b1;
          cnt_val  = LD_ENTRY;
        end
      end
      SLP_ENTER: begin
        if (!sync_sleep)   state_d = SLP_AWAKE;
        else if (cnt_zero) state_d = SLP_ASLEEP;
      end
      SLP_ASLEEP: begin
        if (!sync_sleep) begin
          state_d  = SLP_EXIT;
          cnt_load = 1'b1;
          cnt_val  = LD_EXIT;
        end
      end
      SLP_EXIT: begin
        if (sync_sleep) begin
          state_d = SLP_ASLEEP;
        end else if (cnt_zero) begin
          state_d  = SLP_RECOVER;
          cnt_load = 1'b1;
          cnt_val  = LD_REC;
        end
      end
      SLP_RECOVER: begin
        if (cnt_zero) state_d = SLP_AWAKE;
      end
      default: state_d = SLP_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLP_AWAKE;
    else        state_q <= state_d;
  end

  assign sleep_active   = (state_q == SLP_ASLEEP) || (state_q == SLP_EXIT);
  assign access_inhibit = (state_q != SLP_AWAKE);

  // sleeping always implies blocked accesses
  p_inhibit_covers_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_active |-> access_inhibit);

  // sleep is reached only through the entry phase
  p_sleep_via_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_active) |-> ($past(state_q) == SLP_ENTER || $past(state_q) == SLP_EXIT));

  // accesses are released only at the end of recovery or after an aborted entry
  p_release_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(access_inhibit) |-> ($past(state_q) == SLP_RECOVER || $past(state_q) == SLP_ENTER));

  // an aborted entry needs the synchronized request to have gone
  p_abort_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(access_inhibit) && $past(state_q) == SLP_ENTER) |-> !$past(sync_sleep));
endmodule

// File: tb/sleep_ctrl_tb.sv
module sleep_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRY = 2;
  localparam int EXITL = 2;
  localparam int REC   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_pin = 1'b0;
  logic cs_active = 1'b0;
  logic strobe_proc = 1'b0;
  logic strobe_ctrl = 1'b0;
  logic sleep_active, access_inhibit, proto_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  bit compare_on = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_ctrl #(
    .SYNC_STAGES(2), .ENTRY_CYCLES(ENTRY), .EXIT_CYCLES(EXITL), .RECOVER_CYCLES(REC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .cs_active(cs_active),
    .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
    .sleep_active(sleep_active), .access_inhibit(access_inhibit), .proto_err(proto_err)
  );

  // Behavioural reference: phase 0 awake, 1 entering, 2 asleep, 3 leaving, 4 recovery
  bit pipe[$];
  int phase = 0;
  int rem = 0;
  bit m_err = 0;

  initial begin pipe.push_back(1'b0); pipe.push_back(1'b0); end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe.delete(); pipe.push_back(1'b0); pipe.push_back(1'b0);
      phase = 0; rem = 0; m_err = 0;
    end else begin
      bit req;
      bit any;
      bit sel;
      req = pipe[1];
      any = cs_active || strobe_proc || strobe_ctrl;
      sel = cs_active && (strobe_proc || strobe_ctrl);
      m_err = (phase == 4 && any) || (phase == 0 && req && sel);
      case (phase)
        0: if (req && !sel) begin phase = 1; rem = ENTRY; end
        1: if (!req) phase = 0;
           else begin rem--; if (rem == 0) phase = 2; end
        2: if (!req) begin phase = 3; rem = EXITL; end
        3: if (req) phase = 2;
           else begin rem--; if (rem == 0) begin phase = 4; rem = REC; end end
        default: begin rem--; if (rem == 0) phase = 0; end
      endcase
      pipe.pop_back();
      pipe.push_front(sleep_pin);
    end
  end

  task automatic check(input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && !done) begin
      check("sleep_active", sleep_active, (phase == 2 || phase == 3));
      check("access_inhibit", access_inhibit, (phase != 0));
      check("proto_err", proto_err, m_err);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    cyc(2);
    cur_req = "R1";
    check("reset sleep_active", sleep_active, 1'b0);
    check("reset access_inhibit", access_inhibit, 1'b0);
    check("reset proto_err", proto_err, 1'b0);
    rst_n = 1'b1;
    compare_on = 1;
    cyc(5);

    // R9: awake traffic of several patterns
    cur_req = "R9";
    for (int i = 0; i < 8; i++) begin
      cs_active = i[0]; strobe_proc = i[1]; strobe_ctrl = i[2];
      cyc(1);
    end
    cs_active = 0; strobe_proc = 0; strobe_ctrl = 0;
    cyc(2);

    // R2: entry timing, directed edge counts
    cur_req = "R2";
    sleep_pin = 1'b1;
    cyc(2);
    check("inhibit not yet after edge k+1", access_inhibit, 1'b0);
    cyc(1);
    check("inhibit after edge k+2", access_inhibit, 1'b1);
    cyc(1);
    check("still entering after edge k+3", sleep_active, 1'b0);
    cyc(1);
    check("asleep after edge k+4", sleep_active, 1'b1);

    // R4: selects while asleep are blocked and not flagged
    cur_req = "R4";
    cs_active = 1; strobe_proc = 1; cyc(2);
    strobe_proc = 0; strobe_ctrl = 1; cyc(2);
    cs_active = 0; strobe_ctrl = 0; cyc(1);
    check("no error while asleep", proto_err, 1'b0);

    // R5: exit timing and recovery window
    cur_req = "R5";
    sleep_pin = 1'b0;
    cyc(4);
    check("asleep through edge k+3", sleep_active, 1'b1);
    cyc(1);
    check("awake after edge k+4", sleep_active, 1'b0);
    check("recovery inhibits", access_inhibit, 1'b1);
    cyc(REC - 1);
    check("inhibit last recovery cycle", access_inhibit, 1'b1);
    cyc(1);
    check("released after recovery", access_inhibit, 1'b0);
    cyc(3);

    // R3: aborted entry
    cur_req = "R3";
    sleep_pin = 1'b1; cyc(1); sleep_pin = 1'b0;
    cyc(2);
    check("entry started", access_inhibit, 1'b1);
    cyc(1);
    check("entry aborted", access_inhibit, 1'b0);
    check("never slept", sleep_active, 1'b0);
    cyc(4);

    // R6: request returns during exit latency
    cur_req = "R6";
    sleep_pin = 1'b1; cyc(8);
    sleep_pin = 1'b0; cyc(1); sleep_pin = 1'b1;
    cyc(6);
    check("back asleep", sleep_active, 1'b1);

    // R7: strobe inside recovery window
    cur_req = "R7";
    sleep_pin = 1'b0; cyc(5);
    strobe_ctrl = 1'b1; cyc(1); strobe_ctrl = 1'b0;
    check("error pulse", proto_err, 1'b1);
    cyc(1);
    check("error single cycle", proto_err, 1'b0);
    cs_active = 1'b1; cyc(1); cs_active = 1'b0;
    cyc(6);
    check("window not extended", access_inhibit, 1'b0);

    // R8: sleep request while selected
    cur_req = "R8";
    cs_active = 1; strobe_proc = 1;
    sleep_pin = 1'b1;
    cyc(3);
    check("entry held off", access_inhibit, 1'b0);
    check("select flagged", proto_err, 1'b1);
    cyc(2);
    cs_active = 0; strobe_proc = 0;
    cyc(2);
    check("entry begins once deselected", access_inhibit, 1'b1);
    cyc(4);
    sleep_pin = 1'b0;
    cyc(12);
    check("fully awake", access_inhibit, 1'b0);
    finish_run();
  end
endmodule